// File: doc/BRIEF.md
# GPIO Interrupt Cause Aggregator

This block is the interrupt section of a 32-pin general-purpose I/O port. It receives the input vector after the port has synchronized it and applied any per-pin inversion, so a `1` always means "active". A transition of any such pin from 0 to 1 is latched into an edge cause register. The pin's live value also serves directly as its level cause, with no latch in between.

Two mask registers choose which pins may raise a request: one for latched edges and one for live levels. The pending vector is the OR of both masked sources. It is folded in groups of eight neighbouring pins into one registered request line per group, and each line feeds the main interrupt controller.

Software reaches the three registers over a simple 32-bit register bus. Edge causes are acknowledged by writing a zero to the bit. Detecting falling edges or both edges is done outside the block, by flipping the pin's inversion.

Top module: `gia_irq_agg`

## Requirements
- R1: After reset the edge cause, edge mask and level mask registers all read zero and every request output is low.
- R2: When a pin goes from 0 to 1 between two clock edges, its bit in the edge cause register (address 0x14) reads 1 after the next rising clock edge. This holds whatever the masks are set to.
- R3: A falling transition, a steady level, or a pin that is already high when reset is released sets no edge cause bit.
- R4: Writing the edge cause register clears each bit whose write-data bit is 0. A bit whose write-data bit is 1 keeps its value.
- R5: If a new rising edge and a clearing write hit the same edge cause bit in the same cycle, the bit ends up set.
- R6: A pin whose level mask bit is 1 asserts its group's request while its input is 1. The request drops once the input returns to 0, without any acknowledge.
- R7: A latched edge cause raises a request only if the pin's edge mask bit is 1.
- R8: Request output bit g is the OR of the pending bits of pins 8g to 8g+7, so pins 0-7 drive bit 0 and pins 24-31 drive bit 3.
- R9: The request outputs are registered. They change one clock edge after the cause, mask or input change that caused the change.
- R10: The edge mask sits at address 0x18 plus the parameter MASK_OFS and the level mask at 0x1C plus MASK_OFS. Writes to other addresses change nothing, and reads of other addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Synchronized, polarity-corrected pin inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte address |
| bus_wdata | input | NPINS | Register write data |
| bus_rdata | output | NPINS | Register read data for bus_addr (combinational) |
| irq_req | output | NPINS/GROUP | Registered per-group interrupt requests |

## Verification
The bench builds the block with 32 pins in groups of eight and with MASK_OFS set to 0x40. With that offset the mask registers move to 0x58 and 0x5C. This makes it possible to show that the unshifted mask addresses are then unmapped, which a zero offset could never reveal. The full 32-pin width with four groups lets each group's highest pin be driven alone. It also lets two groups be driven together, to check the folding into the request outputs.

// File: rtl/gia_pkg.sv
package gia_pkg;
  // Fixed register placement; the two mask addresses are shifted by MASK_OFS.
  localparam int unsigned CAUSE_ADDR      = 32'h14;
  localparam int unsigned EDGE_MASK_BASE  = 32'h18;
  localparam int unsigned LEVEL_MASK_BASE = 32'h1C;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_EMASK = 2'd2,
    SEL_LMASK = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gia_edge_det.sv
module gia_edge_det #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q, prev_d;
  logic         armed_q, armed_d;

  always_comb begin
    prev_d  = din;
    armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      armed_q <= armed_d;
    end
  end

  // The first cycle after reset only captures; a pin already high is no edge.
  assign rise = din & ~prev_q & {W{armed_q}};
endmodule

// File: rtl/gia_cause_reg.sv
module gia_cause_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] rise,
  output logic [W-1:0] cause
);
  logic [W-1:0] cause_q, cause_d;

  always_comb begin
    cause_d = cause_q;
    if (wr_en) cause_d = cause_d & wdata;
    cause_d = cause_d | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  assign cause = cause_q;

  // R5
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause & $past(rise)) == $past(rise)));

  // R4
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((cause & $past(cause)) == $past(cause)));
endmodule

// File: rtl/gia_mask_reg.sv
module gia_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_d;

  always_comb begin
    q_d = q_r;
    if (wr_en) q_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/gia_group_req.sv
module gia_group_req #(
  parameter int W     = 32,
  parameter int GROUP = 8,
  localparam int NGRP = W / GROUP
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    pend,
  output logic [NGRP-1:0] req
);
  logic [NGRP-1:0] req_q, req_d;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_comb req_d[g] = |pend[g*GROUP +: GROUP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  assign req = req_q;
endmodule

// File: rtl/gia_irq_agg.sv
module gia_irq_agg
  import gia_pkg::*;
#(
  parameter int          NPINS    = 32,
  parameter int          GROUP    = 8,
  parameter int          AW       = 8,
  parameter int unsigned MASK_OFS = 0,
  localparam int NGRP = NPINS / GROUP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  output logic [NGRP-1:0]  irq_req
);
  localparam logic [AW-1:0] A_CAUSE = AW'(CAUSE_ADDR);
  localparam logic [AW-1:0] A_EMASK = AW'(EDGE_MASK_BASE + MASK_OFS);
  localparam logic [AW-1:0] A_LMASK = AW'(LEVEL_MASK_BASE + MASK_OFS);

  reg_sel_e         sel;
  logic [NPINS-1:0] rise, cause, emask, lmask, pend;

  always_comb begin
    if      (bus_addr == A_CAUSE) sel = SEL_CAUSE;
    else if (bus_addr == A_EMASK) sel = SEL_EMASK;
    else if (bus_addr == A_LMASK) sel = SEL_LMASK;
    else                          sel = SEL_NONE;
  end

  gia_edge_det #(.W(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .rise(rise)
  );

  gia_cause_reg #(.W(NPINS)) u_cause (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && sel == SEL_CAUSE),
    .wdata(bus_wdata), .rise(rise), .cause(cause)
  );

  gia_mask_reg #(.W(NPINS)) u_emask (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && sel == SEL_EMASK),
    .wdata(bus_wdata), .q(emask)
  );

  gia_mask_reg #(.W(NPINS)) u_lmask (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && sel == SEL_LMASK),
    .wdata(bus_wdata), .q(lmask)
  );

  always_comb pend = (pin_in & lmask) | (cause & emask);

  gia_group_req #(.W(NPINS), .GROUP(GROUP)) u_grp (
    .clk(clk), .rst_n(rst_n), .pend(pend), .req(irq_req)
  );

  always_comb begin
    unique case (sel)
      SEL_CAUSE: bus_rdata = cause;
      SEL_EMASK: bus_rdata = emask;
      SEL_LMASK: bus_rdata = lmask;
      default:   bus_rdata = '0;
    endcase
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (irq_req == '0 && cause == '0));

  // R7
  masks_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emask == '0 && lmask == '0) |=> irq_req == '0);

  // R6
  level_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_in & lmask) != '0) |=> irq_req != '0);
endmodule

// File: tb/test_gia_irq_agg.sv
module test_gia_irq_agg;
  localparam int NPINS = 32;
  localparam int GROUP = 8;
  localparam int AW    = 8;
  localparam int unsigned MO = 32'h40;
  localparam logic [7:0] A_CAUSE = 8'h14;
  localparam logic [7:0] A_EMASK = 8'h58;
  localparam logic [7:0] A_LMASK = 8'h5C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pin_in;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_req;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  gia_irq_agg #(.NPINS(NPINS), .GROUP(GROUP), .AW(AW), .MASK_OFS(MO)) i_gia_irq_agg (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_read(A_CAUSE, v); chk("R1 cause", v, 0);
    bus_read(A_EMASK, v); chk("R1 emask", v, 0);
    bus_read(A_LMASK, v); chk("R1 lmask", v, 0);
    chk("R1 irq", {28'd0, irq_req}, 0);
    // pin 31 was high across reset release
    bus_read(A_CAUSE, v); chk("R3 held high through reset", v, 0);
  endtask

  task automatic t_fall();
    logic [31:0] v;
    pin_in = 32'h0; tick(); tick();
    bus_read(A_CAUSE, v); chk("R3 falling edge", v, 0);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    pin_in[3] = 1'b1; tick();
    bus_read(A_CAUSE, v); chk("R2 rise latched", v, 32'h8);
    tick();
    chk("R7 unmasked edge no irq", {28'd0, irq_req}, 0);
  endtask

  task automatic t_emask();
    bus_write(A_EMASK, 32'h8);
    chk("R9 irq lags mask", {28'd0, irq_req}, 0);
    tick();
    chk("R8 group0 edge irq", {28'd0, irq_req}, 32'h1);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    bus_write(A_CAUSE, 32'hFFFF_FFFF);
    bus_read(A_CAUSE, v); chk("R4 write one keeps", v, 32'h8);
    bus_write(A_CAUSE, 32'hFFFF_FFF7);
    bus_read(A_CAUSE, v); chk("R4 write zero clears", v, 0);
    chk("R9 irq lags clear", {28'd0, irq_req}, 32'h1);
    tick();
    chk("R4 irq drops", {28'd0, irq_req}, 0);
  endtask

  task automatic t_race();
    logic [31:0] v;
    pin_in[3] = 1'b0; tick();
    pin_in[3] = 1'b1;
    bus_write(A_CAUSE, 32'h0);
    bus_read(A_CAUSE, v); chk("R5 edge beats clear", v, 32'h8);
    bus_write(A_CAUSE, 32'h0);
    bus_read(A_CAUSE, v); chk("R4 clear after race", v, 0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    bus_write(A_LMASK, 32'h0010_0000);
    tick();
    pin_in[20] = 1'b1; tick();
    chk("R6 level irq group2", {28'd0, irq_req}, 32'h4);
    pin_in[20] = 1'b0; tick();
    chk("R6 level follows input", {28'd0, irq_req}, 0);
    bus_read(A_CAUSE, v); chk("R7 masked edge latched only", v, 32'h0010_0000);
    bus_write(A_CAUSE, 32'h0);
  endtask

  task automatic t_groups();
    bus_write(A_EMASK, 32'h0);
    bus_write(A_LMASK, 32'hFFFF_FFFF);
    for (int g = 0; g < 4; g++) begin
      pin_in = 32'h1 << (8 * g + 7);
      tick();
      chk("R8 top pin of group", {28'd0, irq_req}, 32'h1 << g);
    end
    pin_in = 32'h0100_0001; tick();
    chk("R8 two groups", {28'd0, irq_req}, 32'h9);
    pin_in = 32'h0; tick();
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    bus_write(A_LMASK, 32'h0);
    bus_write(8'h18, 32'hFFFF_FFFF);
    bus_write(8'h1C, 32'hFFFF_FFFF);
    bus_read(A_EMASK, v); chk("R10 emask untouched", v, 0);
    bus_read(A_LMASK, v); chk("R10 lmask untouched", v, 0);
    bus_read(8'h18, v);   chk("R10 unmapped reads zero", v, 0);
    pin_in = 32'h0000_FF00; tick(); tick();
    chk("R10 no irq from unmapped write", {28'd0, irq_req}, 0);
    pin_in = 32'h0;
  endtask

  initial begin
    rst_n = 1'b0; pin_in = 32'h8000_0000;
    bus_wr = 1'b0; bus_addr = 8'h0; bus_wdata = 32'h0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick(); tick();
    t_reset();
    t_fall();
    t_rise();
    t_emask();
    t_clear();
    t_race();
    t_level();
    t_groups();
    t_unmapped();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule